// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Set/Clear Aliases

This block controls a bank of general-purpose pins. Each pin can be handed to a peripheral function, or it can stay under software control as a GPIO. For GPIO use there is an output-value register and an output-direction register. Each of them can be written whole, or changed through a write-one-to-set alias and a write-one-to-clear alias. Independent software threads can therefore flip their own bits without a read-modify-write sequence.

Two independent write channels share the register file, so two masters can update it in the same cycle. A separate input-enable register gates each pin's input buffer. The pad inputs pass through a synchronizer before they can be read back. When reset releases, every pin is a GPIO with its output driver and its input buffer both off.

The block drives per-pin output-enable, output-value and mux-select lines toward a pad ring. The pad electrical model and the peripheral functions sit outside it.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, output value, direction, input-enable and function-select all read 0 (every pin in GPIO mode), and pad_oe, pad_out and mux_sel are all 0.
- R2: A write to address 0 (value register) loads all pin bits from wr_data[NPINS-1:0]. Reads of addresses 0, 1 and 2 return the value register.
- R3: A write to address 1 sets each value bit whose wr_data bit is 1 and leaves the other bits unchanged.
- R4: A write to address 2 clears each value bit whose wr_data bit is 1 and leaves the other bits unchanged.
- R5: The direction register (bit 1 = output) is loaded whole at address 3, set per bit at address 4 and cleared per bit at address 5. Reads of addresses 3, 4 and 5 return it.
- R6: Within one cycle, across both write channels, a clear of a bit beats a set of that bit, and a set beats a whole-register write.
- R7: Address 7 is the function register (bit 1 = peripheral) and address 6 the input-enable register, both loaded whole. mux_sel equals the function register. pad_oe = direction AND NOT function. pad_out = value AND NOT function.
- R8: A read of address 8 returns the synchronized pad input ANDed with input-enable, so a pin with its input disabled reads 0.
- R9: A change on pad_in appears at address 8 after exactly two rising clock edges.
- R10: When both channels write whole to the same register in one cycle, channel 0's value is taken.
- R11: Writes to addresses 9 to 15 change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NWP | Write strobe per channel |
| wr_addr | input | NWP x 4 | Register address per channel |
| wr_data | input | NWP x DW | Write data per channel |
| rd_addr | input | 4 | Read address |
| rd_data | output | DW | Combinational read data |
| pad_in | input | NPINS | Raw pad inputs |
| pad_out | output | NPINS | Output value to pads |
| pad_oe | output | NPINS | Output driver enable to pads |
| mux_sel | output | NPINS | Per-pin peripheral select |

## Verification
The hardest case to reach is two channels hitting the same bit in the same cycle with different kinds of write: a set against a clear, a set against a whole-register write, or two whole-register writes. The random stimulus draws both channels' addresses from a small pool, so these collisions happen often. Directed cycles then pin down each pairing on known bit patterns. Input gating and latency are checked by toggling pad_in while input-enable changes underneath it.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;
   localparam int REG_AW = 4;
   typedef enum logic [REG_AW-1:0] {
      A_VAL     = 4'd0,
      A_VAL_SET = 4'd1,
      A_VAL_CLR = 4'd2,
      A_DIR     = 4'd3,
      A_DIR_SET = 4'd4,
      A_DIR_CLR = 4'd5,
      A_INEN    = 4'd6,
      A_FUNC    = 4'd7,
      A_PINS    = 4'd8
   } reg_addr_e;
endpackage

// File: rtl/pinbank_wdec.sv
`timescale 1ns/1ps
module pinbank_wdec
   import pinbank_pkg::*;
#(
   parameter int NPINS = 16,
   parameter int DW    = 16
) (
   input  logic              en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DW-1:0]     data,
   output logic              ld_val,
   output logic              ld_dir,
   output logic              ld_inen,
   output logic              ld_func,
   output logic [NPINS-1:0]  bits,
   output logic [NPINS-1:0]  set_val,
   output logic [NPINS-1:0]  clr_val,
   output logic [NPINS-1:0]  set_dir,
   output logic [NPINS-1:0]  clr_dir
);
   assign bits    = data[NPINS-1:0];
   assign ld_val  = en && (addr == A_VAL);
   assign ld_dir  = en && (addr == A_DIR);
   assign ld_inen = en && (addr == A_INEN);
   assign ld_func = en && (addr == A_FUNC);
   assign set_val = (en && addr == A_VAL_SET) ? bits : '0;
   assign clr_val = (en && addr == A_VAL_CLR) ? bits : '0;
   assign set_dir = (en && addr == A_DIR_SET) ? bits : '0;
   assign clr_dir = (en && addr == A_DIR_CLR) ? bits : '0;
endmodule

// File: rtl/pinbank_bitreg.sv
`timescale 1ns/1ps
module pinbank_bitreg #(
   parameter int W   = 16,
   parameter int NWP = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NWP-1:0]        ld,
   input  logic [NWP-1:0][W-1:0] ld_bits,
   input  logic [NWP-1:0][W-1:0] set_m,
   input  logic [NWP-1:0][W-1:0] clr_m,
   output logic [W-1:0]          q
);
   logic [W-1:0] base, sets, clrs, nxt;

   always_comb begin
      base = q;
      sets = '0;
      clrs = '0;
      // lowest channel index applied last so it wins whole writes
      for (int p = NWP-1; p >= 0; p--) begin
         if (ld[p]) base = ld_bits[p];
      end
      for (int p = 0; p < NWP; p++) begin
         sets = sets | set_m[p];
         clrs = clrs | clr_m[p];
      end
      nxt = (base | sets) & ~clrs;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_ctrl.sv
`timescale 1ns/1ps
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int DW          = 16,
   parameter int NWP         = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NWP-1:0]               wr_en,
   input  logic [NWP-1:0][REG_AW-1:0]   wr_addr,
   input  logic [NWP-1:0][DW-1:0]       wr_data,
   input  logic [REG_AW-1:0]            rd_addr,
   output logic [DW-1:0]                rd_data,
   input  logic [NPINS-1:0]             pad_in,
   output logic [NPINS-1:0]             pad_out,
   output logic [NPINS-1:0]             pad_oe,
   output logic [NPINS-1:0]             mux_sel
);
   localparam int PAD_W = DW - NPINS;

   generate
      if (NPINS < 1 || NPINS > DW) begin : g_bad_width
         $error("pinbank_ctrl: NPINS must be 1..DW");
      end
      if (NWP < 1) begin : g_bad_ports
         $error("pinbank_ctrl: NWP must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pinbank_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NWP-1:0]             ld_val, ld_dir, ld_inen, ld_func;
   logic [NWP-1:0][NPINS-1:0]  bits, set_val, clr_val, set_dir, clr_dir;
   logic [NWP-1:0][NPINS-1:0]  no_bits;
   logic [NPINS-1:0]           val_q, dir_q, inen_q, func_q, pins_sync, pins_rd;

   assign no_bits = '0;

   generate
      for (genvar p = 0; p < NWP; p++) begin : g_chan
         pinbank_wdec #(.NPINS(NPINS), .DW(DW)) u_dec (
            .en      (wr_en[p]),
            .addr    (wr_addr[p]),
            .data    (wr_data[p]),
            .ld_val  (ld_val[p]),
            .ld_dir  (ld_dir[p]),
            .ld_inen (ld_inen[p]),
            .ld_func (ld_func[p]),
            .bits    (bits[p]),
            .set_val (set_val[p]),
            .clr_val (clr_val[p]),
            .set_dir (set_dir[p]),
            .clr_dir (clr_dir[p])
         );
      end
   endgenerate

   pinbank_bitreg #(.W(NPINS), .NWP(NWP)) u_val (
      .clk(clk), .rst_n(rst_n), .ld(ld_val), .ld_bits(bits),
      .set_m(set_val), .clr_m(clr_val), .q(val_q));

   pinbank_bitreg #(.W(NPINS), .NWP(NWP)) u_dir (
      .clk(clk), .rst_n(rst_n), .ld(ld_dir), .ld_bits(bits),
      .set_m(set_dir), .clr_m(clr_dir), .q(dir_q));

   pinbank_bitreg #(.W(NPINS), .NWP(NWP)) u_inen (
      .clk(clk), .rst_n(rst_n), .ld(ld_inen), .ld_bits(bits),
      .set_m(no_bits), .clr_m(no_bits), .q(inen_q));

   pinbank_bitreg #(.W(NPINS), .NWP(NWP)) u_func (
      .clk(clk), .rst_n(rst_n), .ld(ld_func), .ld_bits(bits),
      .set_m(no_bits), .clr_m(no_bits), .q(func_q));

   pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync));

   assign pins_rd = pins_sync & inen_q;
   assign mux_sel = func_q;
   assign pad_oe  = dir_q & ~func_q;
   assign pad_out = val_q & ~func_q;

   logic [NPINS-1:0] rd_pins;
   always_comb begin
      case (rd_addr)
         A_VAL, A_VAL_SET, A_VAL_CLR: rd_pins = val_q;
         A_DIR, A_DIR_SET, A_DIR_CLR: rd_pins = dir_q;
         A_INEN:                      rd_pins = inen_q;
         A_FUNC:                      rd_pins = func_q;
         A_PINS:                      rd_pins = pins_rd;
         default:                     rd_pins = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_rd_ext
         assign rd_data = {{PAD_W{1'b0}}, rd_pins};
      end else begin : g_rd_exact
         assign rd_data = rd_pins;
      end
   endgenerate
endmodule

// File: rtl/pinbank_chk.sv
`timescale 1ns/1ps
module pinbank_chk
   import pinbank_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int DW          = 16,
   parameter int NWP         = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NWP-1:0]             wr_en,
   input logic [NWP-1:0][REG_AW-1:0] wr_addr,
   input logic [NWP-1:0][DW-1:0]     wr_data,
   input logic [REG_AW-1:0]          rd_addr,
   input logic [DW-1:0]              rd_data,
   input logic [NPINS-1:0]           pad_in,
   input logic [NPINS-1:0]           pad_out,
   input logic [NPINS-1:0]           pad_oe,
   input logic [NPINS-1:0]           mux_sel,
   input logic [NPINS-1:0]           val_q,
   input logic [NPINS-1:0]           inen_q
);
   logic [NPINS-1:0] vset, vclr, dclr, vset_only;
   logic [1:0]       since_rst;

   always_comb begin
      vset = '0; vclr = '0; dclr = '0;
      for (int p = 0; p < NWP; p++) begin
         if (wr_en[p] && wr_addr[p] == A_VAL_SET) vset = vset | wr_data[p][NPINS-1:0];
         if (wr_en[p] && wr_addr[p] == A_VAL_CLR) vclr = vclr | wr_data[p][NPINS-1:0];
         if (wr_en[p] && wr_addr[p] == A_DIR_CLR) dclr = dclr | wr_data[p][NPINS-1:0];
      end
      vset_only = vset & ~vclr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && mux_sel == '0 && pad_out == '0));

   assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|vset_only) |=> ((val_q & $past(vset_only)) == $past(vset_only)));

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|vclr) |=> ((val_q & $past(vclr)) == '0));

   assert_dir_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|dclr) |=> ((pad_oe & $past(dclr)) == '0));

   assert_periph_no_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & mux_sel) == '0);

   assert_input_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_PINS) |-> ((rd_data[NPINS-1:0] & ~inen_q) == '0));

   generate
      if (SYNC_STAGES == 2) begin : g_lat
         assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && rd_addr == A_PINS)
               |-> (rd_data[NPINS-1:0] == ($past(pad_in, 2) & inen_q)));
      end
   endgenerate
endmodule

bind pinbank_ctrl pinbank_chk #(
   .NPINS(NPINS), .DW(DW), .NWP(NWP), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
   .mux_sel(mux_sel), .val_q(val_q), .inen_q(inen_q)
);

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;
   localparam int NP = 16;
   localparam int DW = 16;
   localparam int NW = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NW-1:0]        wr_en = '0;
   logic [NW-1:0][3:0]   wr_addr = '0;
   logic [NW-1:0][DW-1:0] wr_data = '0;
   logic [3:0]           rd_addr = '0;
   logic [DW-1:0]        rd_data;
   logic [NP-1:0]        pad_in = '0;
   logic [NP-1:0]        pad_out, pad_oe, mux_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [NP-1:0] m_val, m_dir, m_inen, m_func, m_s1, m_s2;

   always #10 clk = ~clk;

   pinbank_ctrl #(.NPINS(NP), .DW(DW), .NWP(NW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .mux_sel(mux_sel));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // register update rule: whole write (channel 0 wins), then sets, then clears
   function automatic logic [NP-1:0] next_reg(input logic [NP-1:0] cur,
         input int a_ld, input int a_set, input int a_clr);
      logic [NP-1:0] r = cur;
      logic [NP-1:0] s = '0;
      logic [NP-1:0] c = '0;
      for (int p = NW-1; p >= 0; p--)
         if (wr_en[p] && int'(wr_addr[p]) == a_ld) r = wr_data[p][NP-1:0];
      for (int p = 0; p < NW; p++) begin
         if (wr_en[p] && int'(wr_addr[p]) == a_set) s = s | wr_data[p][NP-1:0];
         if (wr_en[p] && int'(wr_addr[p]) == a_clr) c = c | wr_data[p][NP-1:0];
      end
      return (r | s) & ~c;
   endfunction

   function automatic logic [NP-1:0] expect_rd(input int a);
      case (a)
         0, 1, 2: return m_val;
         3, 4, 5: return m_dir;
         6:       return m_inen;
         7:       return m_func;
         8:       return m_s2 & m_inen;
         default: return '0;
      endcase
   endfunction

   // called at a falling edge with inputs already driven
   task automatic step();
      @(posedge clk);
      #1;
      m_val  = next_reg(m_val, 0, 1, 2);
      m_dir  = next_reg(m_dir, 3, 4, 5);
      m_inen = next_reg(m_inen, 6, -1, -1);
      m_func = next_reg(m_func, 7, -1, -1);
      m_s2   = m_s1;
      m_s1   = pad_in;
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic verify_all();
      chk("R7 mux_sel", 32'(mux_sel), 32'(m_func));
      chk("R7 pad_oe",  32'(pad_oe),  32'(m_dir & ~m_func));
      chk("R7 pad_out", 32'(pad_out), 32'(m_val & ~m_func));
      for (int a = 0; a < 16; a++) begin
         rd_addr = 4'(a);
         #0.5;
         if (a <= 2)      chk("R2 value read", 32'(rd_data), 32'(expect_rd(a)));
         else if (a <= 5) chk("R5 dir read", 32'(rd_data), 32'(expect_rd(a)));
         else if (a <= 7) chk("R7 cfg read", 32'(rd_data), 32'(expect_rd(a)));
         else if (a == 8) chk("R8 pin read", 32'(rd_data), 32'(expect_rd(a)));
         else             chk("R11 unmapped read", 32'(rd_data), 32'h0);
      end
   endtask

   task automatic put(input int p, input int a, input logic [15:0] d);
      wr_en[p] = 1'b1;
      wr_addr[p] = 4'(a);
      wr_data[p] = DW'(d);
   endtask

   task automatic rd_now(input int a, output logic [NP-1:0] v);
      rd_addr = 4'(a);
      #0.5;
      v = rd_data[NP-1:0];
   endtask

   initial begin
      logic [NP-1:0] v;
      void'($urandom(32'h1f2e3d4c));
      m_val = '0; m_dir = '0; m_inen = '0; m_func = '0; m_s1 = '0; m_s2 = '0;
      pad_in = 16'hffff;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pad_oe", 32'(pad_oe), 0);
      chk("R1 pad_out", 32'(pad_out), 0);
      chk("R1 mux_sel", 32'(mux_sel), 0);
      for (int a = 0; a < 9; a++) begin
         rd_now(a, v);
         chk("R1 reg read", 32'(v), 0);
      end
      rst_n = 1'b1;
      m_s1 = '0; m_s2 = '0;
      pad_in = '0;
      step();
      step();

      // R2 whole write then R3 set then R4 clear
      put(0, 0, 16'h00f0); step();
      rd_now(0, v); chk("R2 whole write", 32'(v), 32'h00f0);
      put(1, 1, 16'h0003); step();
      rd_now(1, v); chk("R3 set keeps others", 32'(v), 32'h00f3);
      put(0, 2, 16'h0030); step();
      rd_now(2, v); chk("R4 clear keeps others", 32'(v), 32'h00c3);

      // R5 direction aliases
      put(0, 3, 16'h0f00); step();
      put(0, 4, 16'h0001); step();
      put(1, 5, 16'h0100); step();
      rd_now(3, v); chk("R5 dir set/clear", 32'(v), 32'h0e01);
      chk("R5 pad_oe follows dir", 32'(pad_oe), 32'h0e01);

      // R6 clear beats set across channels, set beats whole write
      put(0, 1, 16'hff00); put(1, 2, 16'h0f00); step();
      rd_now(0, v); chk("R6 clear beats set", 32'(v), 32'hf0c3);
      put(0, 0, 16'h0000); put(1, 1, 16'h8001); step();
      rd_now(0, v); chk("R6 set beats whole write", 32'(v), 32'h8001);

      // R10 both channels whole-write the same register
      put(0, 0, 16'h1234); put(1, 0, 16'habcd); step();
      rd_now(0, v); chk("R10 channel 0 wins", 32'(v), 32'h1234);

      // R11 unmapped writes
      for (int a = 9; a < 16; a++) begin
         put(0, a, 16'hffff); step();
      end
      rd_now(0, v); chk("R11 value untouched", 32'(v), 32'h1234);
      rd_now(3, v); chk("R11 dir untouched", 32'(v), 32'h0e01);
      rd_now(7, v); chk("R11 func untouched", 32'(v), 32'h0000);

      // R7 peripheral handoff
      put(0, 7, 16'h0f0f); step();
      chk("R7 mux_sel", 32'(mux_sel), 32'h0f0f);
      chk("R7 oe masked", 32'(pad_oe), 32'h0e01 & ~32'h0f0f);
      chk("R7 out masked", 32'(pad_out), 32'h1234 & ~32'h0f0f);

      // R8 gating and R9 latency
      pad_in = 16'ha5a5; step(); step();
      rd_now(8, v); chk("R8 input disabled reads 0", 32'(v), 0);
      put(0, 6, 16'h00ff); step();
      rd_now(8, v); chk("R8 input enabled", 32'(v), 32'h00a5);
      pad_in = 16'h5a5a; step();
      rd_now(8, v); chk("R9 one edge: old value", 32'(v), 32'h00a5);
      step();
      rd_now(8, v); chk("R9 two edges: new value", 32'(v), 32'h005a);

      // random mix with frequent collisions
      for (int i = 0; i < 600; i++) begin
         for (int p = 0; p < NW; p++) begin
            if ($urandom_range(0, 3) != 0) begin
               int a;
               a = ($urandom_range(0, 9) == 0) ? int'($urandom_range(9, 15))
                                               : int'($urandom_range(0, 7));
               put(p, a, 16'($urandom));
            end
         end
         if ($urandom_range(0, 2) == 0) pad_in = NP'($urandom);
         step();
         verify_all();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule